// File: doc/BRIEF.md
# Banked Data Address Former

This block sits beside the decoder of a small 8-bit microcontroller core. It turns the operand fields of a byte- or bit-oriented instruction into a 12-bit data-memory address and decides where the result goes. The 8-bit file address from the opcode can be placed inside the bank chosen by a 4-bit bank register. It can also be treated as an entry of a fixed access window made of the bottom and the top of data memory. A two-word move instruction instead supplies a complete 12-bit operand that bypasses the bank register.

The destination logic reads a 2-bit instruction class. Instructions that carry a destination bit write either the file register or the working register, depending on that bit. The other classes name their destination outright, or write nothing. The bank register is loaded through a strobe and takes its new value at the next clock edge. The address outputs are combinational from the inputs and the stored bank value.

Top module: `bank_addr_former`

## Requirements
- R1: With full mode off and the access bit at 1, the source address is the stored bank value in bits 11:8 with the file address in bits 7:0.
- R2: With full mode off, the access bit at 0 and a file address below 0x60, the source address is 0x000 plus the file address, whatever the bank value.
- R3: With full mode off, the access bit at 0 and a file address of 0x60 or above, the source address is 0xF00 plus the file address, whatever the bank value.
- R4: With full mode on, the source address equals the 12-bit full operand; the bank value, the access bit and the file address have no effect.
- R5: The write-back address always equals the source address.
- R6: For class 0 (destination-bit class), a destination bit of 1 raises only the file write enable and a destination bit of 0 raises only the working write enable.
- R7: Class 1 raises only the file write enable, class 2 only the working write enable, and class 3 neither; in these classes the destination bit has no effect.
- R8: The file and working write enables are never high together.
- R9: The bank register is 0 after reset, takes the load data at the first rising edge with the load strobe high, and keeps its value at edges where the strobe is low.
- R10: A bank load does not change the address in the cycle of the strobe; the new bank value appears only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_din | input | 4 | Value loaded into the bank register |
| file_addr | input | 8 | File address from the opcode low byte |
| acc_bit | input | 1 | 1 = bank-relative, 0 = access window |
| dest_bit | input | 1 | 1 = file register, 0 = working register (class 0 only) |
| full_mode | input | 1 | Use the full 12-bit operand |
| full_addr | input | 12 | Full operand of a two-word move |
| iclass | input | 2 | 0 = by destination bit, 1 = file, 2 = working, 3 = none |
| src_addr | output | 12 | Source data address |
| wb_addr | output | 12 | Write-back data address |
| we_file | output | 1 | Write the result to the file register |
| we_work | output | 1 | Write the result to the working register |

## Verification
The hardest case to reach is the one cycle in which a bank load is pending: the strobe is high and a banked instruction is on the inputs at the same time. The old bank value must still shape the address, and the new one must appear right after the edge. The bench first loads a known nonzero bank. In one low clock phase it then raises the strobe with different data, samples the banked address before the edge and samples it again after the edge. The access-window split is also probed on both sides of 0x60 while a nonzero bank is stored, so that any leak of the bank into the window shows up.

// File: rtl/bank_addr_former.sv
module bank_addr_former #(
  parameter int AW    = 12,
  parameter int FW    = 8,
  parameter int BW    = AW - FW,
  parameter int SPLIT = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_ld,
  input  logic [BW-1:0] bank_din,
  input  logic [FW-1:0] file_addr,
  input  logic          acc_bit,
  input  logic          dest_bit,
  input  logic          full_mode,
  input  logic [AW-1:0] full_addr,
  input  logic [1:0]    iclass,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] wb_addr,
  output logic          we_file,
  output logic          we_work
);
  localparam int HW = AW - FW;
  localparam logic [FW-1:0] SPLIT_V = FW'(SPLIT);

  logic [BW-1:0] bank;
  logic          acc_hi;
  logic [AW-1:0] win_addr;
  logic [AW-1:0] bnk_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank <= '0;
    else if (bank_ld) bank <= bank_din;

  assign acc_hi   = (file_addr >= SPLIT_V);
  assign win_addr = {{HW{acc_hi}}, file_addr};
  assign bnk_addr = {bank, file_addr};
  assign src_addr = full_mode ? full_addr : (acc_bit ? bnk_addr : win_addr);
  assign wb_addr  = src_addr;

  always_comb begin
    we_file = 1'b0;
    we_work = 1'b0;
    case (iclass)
      2'd0: begin we_file = dest_bit; we_work = ~dest_bit; end
      2'd1: we_file = 1'b1;
      2'd2: we_work = 1'b1;
      default: ;
    endcase
  end

  AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_file && we_work)); // R8
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld |=> (bank == $past(bank_din))); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld |=> $stable(bank)); // R9
  AST_WIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && !acc_bit && file_addr >= SPLIT_V) |-> (&src_addr[AW-1:FW])); // R3
  AST_WIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && !acc_bit && file_addr < SPLIT_V) |-> (src_addr[AW-1:FW] == '0)); // R2
  AST_WB_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    wb_addr == src_addr); // R5
  AST_CLASS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (iclass == 2'd3) |-> (!we_file && !we_work)); // R7
endmodule

// File: tb/bank_addr_former_bench.sv
`timescale 1ns/1ps
module bank_addr_former_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_ld = 1'b0;
  logic [3:0]  bank_din = '0;
  logic [7:0]  file_addr = '0;
  logic        acc_bit = 1'b0;
  logic        dest_bit = 1'b0;
  logic        full_mode = 1'b0;
  logic [11:0] full_addr = '0;
  logic [1:0]  iclass = '0;
  logic [11:0] src_addr, wb_addr;
  logic        we_file, we_work;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bank_addr_former u_bank_addr_former (
    .clk(clk), .rst_n(rst_n), .bank_ld(bank_ld), .bank_din(bank_din),
    .file_addr(file_addr), .acc_bit(acc_bit), .dest_bit(dest_bit),
    .full_mode(full_mode), .full_addr(full_addr), .iclass(iclass),
    .src_addr(src_addr), .wb_addr(wb_addr), .we_file(we_file), .we_work(we_work)
  );

  always #2.5 clk = ~clk;

  // {acc, dest, full, iclass, file, full_addr, exp_src, exp_wf, exp_ww}; bank = 3
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 2'd0, 8'h45, 12'h000, 12'h345, 1'b1, 1'b0}, // R1 R6
    {1'b1, 1'b0, 1'b0, 2'd0, 8'hFF, 12'h000, 12'h3FF, 1'b0, 1'b1}, // R1 R6
    {1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 12'h000, 12'h000, 1'b1, 1'b0}, // R2
    {1'b0, 1'b0, 1'b0, 2'd0, 8'h5F, 12'h000, 12'h05F, 1'b0, 1'b1}, // R2
    {1'b0, 1'b1, 1'b0, 2'd0, 8'h60, 12'h000, 12'hF60, 1'b1, 1'b0}, // R3
    {1'b0, 1'b0, 1'b0, 2'd0, 8'hFF, 12'h000, 12'hFFF, 1'b0, 1'b1}, // R3
    {1'b1, 1'b0, 1'b1, 2'd1, 8'h12, 12'hABC, 12'hABC, 1'b1, 1'b0}, // R4 R7
    {1'b0, 1'b1, 1'b1, 2'd2, 8'h70, 12'h060, 12'h060, 1'b0, 1'b1}, // R4 R7
    {1'b1, 1'b1, 1'b0, 2'd3, 8'h80, 12'h000, 12'h380, 1'b0, 1'b0}, // R7
    {1'b0, 1'b0, 1'b0, 2'd1, 8'h20, 12'h000, 12'h020, 1'b1, 1'b0}  // R7
  };

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    acc_bit = 1'b1; file_addr = 8'h00; iclass = 2'd3; #1;
    check("R9 reset bank", src_addr, 12'h000);
    check("R7 class3 none", {10'd0, we_file, we_work}, 12'h000);

    @(negedge clk);
    bank_ld = 1'b1; bank_din = 4'h3;
    @(negedge clk);
    bank_ld = 1'b0;

    for (int i = 0; i < NV; i++) begin
      acc_bit   = VEC[i][38];
      dest_bit  = VEC[i][37];
      full_mode = VEC[i][36];
      iclass    = VEC[i][35:34];
      file_addr = VEC[i][33:26];
      full_addr = VEC[i][25:14];
      #1;
      check($sformatf("R1/R2/R3/R4 src vec%0d", i), src_addr, VEC[i][13:2]);
      check($sformatf("R5 wb vec%0d", i), wb_addr, VEC[i][13:2]);
      check($sformatf("R6/R7/R8 enables vec%0d", i), {10'd0, we_file, we_work},
            {10'd0, VEC[i][1], VEC[i][0]});
      @(negedge clk);
    end

    full_mode = 1'b0; acc_bit = 1'b1; file_addr = 8'h11; iclass = 2'd0; dest_bit = 1'b1;
    bank_ld = 1'b1; bank_din = 4'hA; #1;
    check("R10 old bank in strobe cycle", src_addr, 12'h311);
    @(negedge clk);
    bank_ld = 1'b0; bank_din = 4'h5; #1;
    check("R9 R10 new bank after edge", src_addr, 12'hA11);
    @(negedge clk); #1;
    check("R9 hold without strobe", src_addr, 12'hA11);

    acc_bit = 1'b0; file_addr = 8'h5F; #1;
    check("R2 window low ignores bank", src_addr, 12'h05F);
    file_addr = 8'h60; #1;
    check("R3 window high ignores bank", src_addr, 12'hF60);
    full_mode = 1'b1; full_addr = 12'h7E4; acc_bit = 1'b1; #1;
    check("R4 full ignores bank", src_addr, 12'h7E4);

    full_mode = 1'b0; iclass = 2'd2; dest_bit = 1'b1; #1;
    check("R7 class2 ignores dest", {10'd0, we_file, we_work}, 12'h001);
    iclass = 2'd1; dest_bit = 1'b0; #1;
    check("R7 class1 ignores dest", {10'd0, we_file, we_work}, 12'h002);

    @(negedge clk);
    rst_n = 1'b0; #1;
    acc_bit = 1'b1; file_addr = 8'h01; #1;
    check("R9 async reset clears bank", src_addr, 12'h001);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule